// File: doc/BRIEF.md
# Dual-Channel Disk Controller I/O Address Decoder

This block sits between the host I/O bus and the two channel register blocks of a dual-channel disk controller. Every host access is compared against five programmable address windows: a command window and a control window for each channel, plus one bus-master window that both channels share. The first window that holds the address claims the access. The block then hands the access to the owning channel with an offset measured from the window base. The bus-master window is split between the channels: its lower half goes to channel 0 and its upper half, rebased to zero, goes to channel 1.

Each channel has a drive-select bit, which is set by a write to a fixed command-window offset. Presence inputs show which drive positions are populated on each channel. When a command or control access targets an empty position, the channel port is not strobed and any read returns zero. The window bases are loaded from configuration-write events, and a zero value never replaces a base. An I/O-enable input can silence all accesses. A bus-master-enable input blocks writes to the bus-master window.

The request side is a valid-only stream with no back-pressure: the decoder accepts a request in every cycle that `req_valid` is high. It returns exactly one response beat (`rsp_valid`) in the next cycle, and the host must take that beat. The channel strobe, offset and write data are driven during the request cycle. The channel must present read data on `chan_rdata` in that same cycle.

Top module: `ide_io_decode`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high in the following cycle, with that access's `rsp_rdata` and `rsp_err`. A cycle without a request produces no response beat.
- R2: The windows are checked in this fixed order: channel 0 command, channel 0 control, channel 1 command, channel 1 control, bus-master. Where windows overlap, the earliest one in this order wins. The sizes are 8 bytes for command windows, 4 bytes for control windows and 16 bytes for the bus-master window.
- R3: A claimed access strobes exactly one bit of `chan_stb`, the bit of the owning channel. It drives `chan_off` = address minus window base, and drives `chan_kind` with 0 for command, 1 for control and 2 for bus-master.
- R4: In the bus-master window, offsets 0 to 7 go to channel 0 unchanged. Offsets 8 to 15 go to channel 1 with 8 subtracted.
- R5: With `io_en` low, an access of legal size completes with `rsp_err` low and zero read data. It strobes no channel and leaves the drive-select bits unchanged.
- R6: With `bm_en` low, a write to the bus-master window is dropped, with no strobe and no error. Reads of that window are still forwarded.
- R7: A write to command-window offset 6 loads that channel's drive-select bit from write-data bit 4. The new value is visible on `dev_sel` from the next cycle.
- R8: `dev_present` bit 2*c+s means that channel c has a drive at position s (0 = master, 1 = slave). A command or control access whose selected position is empty strobes nothing and returns zero read data. For a write to offset 6, the newly written select decides this.
- R9: A size other than 1, 2 or 4 bytes gives `rsp_err` with no strobe, whether or not `io_en` is high.
- R10: An enabled access of legal size whose address falls in no window gives `rsp_err`.
- R11: `cfg_bar_we` bit i loads base i from `cfg_bar_val` only when that value is nonzero. Bit order is 0 channel 0 command, 1 channel 0 control, 2 channel 1 command, 3 channel 1 control, 4 bus-master. Reset clears all bases and both select bits.
- R12: The read data of a forwarded read is the owning channel's slice of `chan_rdata`, taken in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O space enable |
| bm_en | input | 1 | Bus-master write enable |
| cfg_bar_we | input | 5 | One-hot base load strobes |
| cfg_bar_val | input | ADDR_W | Base value to load |
| dev_present | input | 4 | Drive presence, bit 2*channel+position |
| req_valid | input | 1 | Request beat valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host I/O address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response beat, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Bad size or unmapped address |
| chan_stb | output | 2 | Per-channel access strobe |
| chan_kind | output | 2 | Window kind of the forwarded access |
| chan_write | output | 1 | Forwarded access is a write |
| chan_off | output | OFF_W | Window-relative offset |
| chan_size | output | 3 | Forwarded access size |
| chan_wdata | output | DATA_W | Forwarded write data |
| chan_rdata | input | 2*DATA_W | Read data from channel 1 (upper) and channel 0 (lower) |
| dev_sel | output | 2 | Drive-select bit per channel |

## Verification
The bench makes two windows overlap and checks that the earlier window keeps the access. A decoder with its priority reversed would route that access to the control port. It walks both halves of the bus-master window, where a missing rebase would show channel 1 at offset 10 instead of 2. It also flips the select bit toward an empty slave position and expects the strobe to drop and the read data to return zero, which a decoder that tested presence against the old select would get wrong. Finally it tests the two enables and the rule that a zero base write is ignored: a write that leaks past a disabled gate shows a stray strobe or a changed select bit, and a base that takes the zero value moves the window so that a later access returns an error.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int NWIN   = 5;
  localparam int W_PCMD = 0;
  localparam int W_PCTL = 1;
  localparam int W_SCMD = 2;
  localparam int W_SCTL = 3;
  localparam int W_BM   = 4;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_CTL  = 2'd1,
    K_BM   = 2'd2,
    K_NONE = 2'd3
  } win_kind_e;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/ide_base_regs.sv
module ide_base_regs
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWIN-1:0]          bar_we,
  input  logic [ADDR_W-1:0]        bar_val,
  output logic [NWIN*ADDR_W-1:0]   bases
);

  logic val_nz;
  assign val_nz = |bar_val;

  for (genvar i = 0; i < NWIN; i++) begin : g_base
    logic [ADDR_W-1:0] base_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                 base_q <= '0;
      else if (bar_we[i] && val_nz) base_q <= bar_val;
    end
    assign bases[i*ADDR_W +: ADDR_W] = base_q;

    AST_BASE_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_we[i] && bar_val == '0) |=> $stable(base_q)); // R11
  end

endmodule

// File: rtl/ide_win_match.sv
module ide_win_match
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CMD_SIZE  = 8,
  parameter int CTRL_SIZE = 4,
  parameter int BM_SIZE   = 16,
  parameter int OFF_W     = 4
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NWIN*ADDR_W-1:0] bases,
  output logic                   any_hit,
  output logic [2:0]             win,
  output logic [OFF_W-1:0]       off
);

  logic [NWIN-1:0]  hit;
  logic [OFF_W-1:0] rel [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int SZ = (i == W_BM) ? BM_SIZE :
                        ((i == W_PCTL) || (i == W_SCTL)) ? CTRL_SIZE : CMD_SIZE;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W:0]   lim;
    assign base   = bases[i*ADDR_W +: ADDR_W];
    assign lim    = {1'b0, base} + (ADDR_W+1)'(SZ);
    assign hit[i] = ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} < lim);
    // offset fits OFF_W bits because the window size is at most 2**OFF_W
    assign rel[i] = addr[OFF_W-1:0] - base[OFF_W-1:0];
  end

  // descending scan: the lowest-numbered matching window is written last
  always_comb begin
    any_hit = 1'b0;
    win     = 3'd0;
    off     = '0;
    for (int i = NWIN-1; i >= 0; i--) begin
      if (hit[i]) begin
        any_hit = 1'b1;
        win     = 3'(i);
        off     = rel[i];
      end
    end
  end

endmodule

// File: rtl/ide_chan_state.sv
module ide_chan_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_we,
  input  logic       sel_val,
  input  logic [1:0] present,
  output logic       sel_q,
  output logic       drive_ok
);

  logic eff_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_we) sel_q <= sel_val;
  end

  // a select write takes effect for its own access
  assign eff_sel  = sel_we ? sel_val : sel_q;
  assign drive_ok = present[eff_sel];

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q)); // R7
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (sel_q == $past(sel_val))); // R7

endmodule

// File: rtl/ide_io_decode.sv
module ide_io_decode
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int CMD_SIZE  = 8,
  parameter int CTRL_SIZE = 4,
  parameter int BM_SIZE   = 16,
  parameter int SEL_OFF   = 6,
  parameter int SEL_BIT   = 4,
  localparam int OFF_W    = $clog2(BM_SIZE),
  localparam int BM_HALF  = BM_SIZE / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_en,
  input  logic                  bm_en,
  input  logic [NWIN-1:0]       cfg_bar_we,
  input  logic [ADDR_W-1:0]     cfg_bar_val,
  input  logic [3:0]            dev_present,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2:0]            req_size,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_err,
  output logic [1:0]            chan_stb,
  output logic [1:0]            chan_kind,
  output logic                  chan_write,
  output logic [OFF_W-1:0]      chan_off,
  output logic [2:0]            chan_size,
  output logic [DATA_W-1:0]     chan_wdata,
  input  logic [2*DATA_W-1:0]   chan_rdata,
  output logic [1:0]            dev_sel
);

  logic [NWIN*ADDR_W-1:0] bases;
  logic                   any_hit;
  logic [2:0]             win;
  logic [OFF_W-1:0]       off_raw, off_adj;
  logic                   sz_ok, go, err_c, bm_hi, ch, bm_drop, fwd;
  win_kind_e              kind;
  logic [1:0]             sel_we, drv_ok;
  logic [DATA_W-1:0]      rd_mux;

  ide_base_regs #(.ADDR_W(ADDR_W)) u_bases (
    .clk(clk), .rst_n(rst_n), .bar_we(cfg_bar_we), .bar_val(cfg_bar_val),
    .bases(bases)
  );

  ide_win_match #(
    .ADDR_W(ADDR_W), .CMD_SIZE(CMD_SIZE), .CTRL_SIZE(CTRL_SIZE),
    .BM_SIZE(BM_SIZE), .OFF_W(OFF_W)
  ) u_match (
    .addr(req_addr), .bases(bases), .any_hit(any_hit), .win(win), .off(off_raw)
  );

  always_comb begin
    unique case (win)
      3'(W_PCMD), 3'(W_SCMD): kind = K_CMD;
      3'(W_PCTL), 3'(W_SCTL): kind = K_CTL;
      3'(W_BM):               kind = K_BM;
      default:                kind = K_NONE;
    endcase
  end

  assign sz_ok   = size_legal(req_size);
  assign go      = req_valid && sz_ok && io_en && any_hit;
  assign err_c   = req_valid && (!sz_ok || (io_en && !any_hit));
  assign bm_hi   = (kind == K_BM) && (off_raw >= OFF_W'(BM_HALF));
  assign ch      = (win == 3'(W_SCMD)) || (win == 3'(W_SCTL)) || bm_hi;
  assign off_adj = bm_hi ? off_raw - OFF_W'(BM_HALF) : off_raw;
  assign bm_drop = (kind == K_BM) && req_write && !bm_en;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    assign sel_we[c] = go && req_write && (kind == K_CMD) && (ch == 1'(c)) &&
                       (off_adj == OFF_W'(SEL_OFF));
    ide_chan_state u_state (
      .clk(clk), .rst_n(rst_n), .sel_we(sel_we[c]),
      .sel_val(req_wdata[SEL_BIT]), .present(dev_present[2*c +: 2]),
      .sel_q(dev_sel[c]), .drive_ok(drv_ok[c])
    );
  end

  assign fwd        = go && !bm_drop && ((kind == K_BM) || drv_ok[ch]);
  assign chan_stb   = fwd ? (ch ? 2'b10 : 2'b01) : 2'b00;
  assign chan_kind  = kind;
  assign chan_write = req_write;
  assign chan_off   = off_adj;
  assign chan_size  = req_size;
  assign chan_wdata = req_wdata;
  assign rd_mux     = (fwd && !req_write) ? chan_rdata[ch*DATA_W +: DATA_W] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= err_c;
      rsp_rdata <= rd_mux;
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_ONE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_stb)); // R3
  AST_IO_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !io_en) |-> (chan_stb == 2'b00)); // R5
  AST_IO_OFF_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !io_en && sz_ok) |=> !rsp_err); // R5
  AST_BM_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !bm_en && any_hit && win == 3'(W_BM))
      |-> (chan_stb == 2'b00)); // R6
  AST_BADSIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sz_ok) |=> rsp_err); // R9

endmodule

// File: tb/ide_io_decode_test.sv
module ide_io_decode_test;

  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_en = 1'b0, bm_en = 1'b0;
  logic [4:0] cfg_bar_we = '0;
  logic [AW-1:0] cfg_bar_val = '0;
  logic [3:0] dev_present = 4'b0101;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_size = 3'd1;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [1:0] chan_stb, chan_kind, dev_sel;
  logic chan_write;
  logic [3:0] chan_off;
  logic [2:0] chan_size;
  logic [DW-1:0] chan_wdata;
  logic [2*DW-1:0] chan_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] mdl(input int c, input logic [1:0] k, input logic [3:0] o);
    return 32'hD000_0000 | (32'(c) << 16) | (32'(k) << 8) | 32'(o);
  endfunction

  assign chan_rdata = {mdl(1, chan_kind, chan_off), mdl(0, chan_kind, chan_off)};

  ide_io_decode uut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
    .cfg_bar_we(cfg_bar_we), .cfg_bar_val(cfg_bar_val), .dev_present(dev_present),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .chan_stb(chan_stb),
    .chan_kind(chan_kind), .chan_write(chan_write), .chan_off(chan_off),
    .chan_size(chan_size), .chan_wdata(chan_wdata), .chan_rdata(chan_rdata),
    .dev_sel(dev_sel)
  );

  logic [1:0] s_stb, s_kind;
  logic [3:0] s_off;
  logic r_valid, r_err;
  logic [31:0] r_data;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setbar(input int i, input logic [AW-1:0] v);
    @(negedge clk);
    cfg_bar_we = 5'(1 << i);
    cfg_bar_val = v;
    @(negedge clk);
    cfg_bar_we = '0;
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [2:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    #2;
    s_stb = chan_stb; s_kind = chan_kind; s_off = chan_off;
    @(negedge clk);
    r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11", "reset dev_sel", 32'(dev_sel), 0);
    chk("R1", "reset rsp_valid", 32'(rsp_valid), 0);
    @(negedge clk);
    chk("R1", "idle rsp_valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_routes;
    access(0, 16'h01F2, 3'd2, 0);
    chk("R3", "pcmd stb", 32'(s_stb), 1);
    chk("R3", "pcmd kind/off", {s_kind, s_off}, {2'd0, 4'd2});
    chk("R1", "pcmd rsp_valid", 32'(r_valid), 1);
    chk("R12", "pcmd rdata", r_data, mdl(0, 0, 2));
    access(0, 16'h0376, 3'd1, 0);
    chk("R3", "sctl stb", 32'(s_stb), 2);
    chk("R12", "sctl rdata", r_data, mdl(1, 1, 2));
    access(0, 16'h0175, 3'd4, 0);
    chk("R3", "scmd kind/off", {s_stb, s_kind, s_off}, {2'd2, 2'd0, 4'd5});
  endtask

  task automatic t_select;
    access(1, 16'h01F6, 3'd1, 32'h10);
    chk("R8", "select-to-absent write stb", 32'(s_stb), 0);
    chk("R7", "dev_sel after select", 32'(dev_sel), 1);
    access(0, 16'h01F2, 3'd1, 0);
    chk("R8", "absent cmd stb", 32'(s_stb), 0);
    chk("R8", "absent cmd rdata", r_data, 0);
    access(0, 16'h03F5, 3'd1, 0);
    chk("R8", "absent ctl rdata", r_data, 0);
    access(1, 16'h01F6, 3'd1, 32'hEF);
    chk("R8", "select-to-present stb", 32'(s_stb), 1);
    chk("R7", "dev_sel restored", 32'(dev_sel), 0);
  endtask

  task automatic t_bm;
    access(0, 16'hC003, 3'd1, 0);
    chk("R4", "bm low half", {s_stb, s_kind, s_off}, {2'd1, 2'd2, 4'd3});
    access(0, 16'hC00A, 3'd2, 0);
    chk("R4", "bm high half", {s_stb, s_kind, s_off}, {2'd2, 2'd2, 4'd2});
    chk("R12", "bm high rdata", r_data, mdl(1, 2, 2));
    bm_en = 1'b0;
    access(1, 16'hC001, 3'd1, 32'h5);
    chk("R6", "bm write dropped", {30'd0, s_stb}, 0);
    chk("R6", "bm drop no err", 32'(r_err), 0);
    access(0, 16'hC00A, 3'd1, 0);
    chk("R6", "bm read with gate off", 32'(s_stb), 2);
    bm_en = 1'b1;
    access(1, 16'hC009, 3'd1, 32'h5);
    chk("R6", "bm write enabled", 32'(s_stb), 2);
  endtask

  task automatic t_io_gate;
    io_en = 1'b0;
    access(0, 16'h01F2, 3'd1, 0);
    chk("R5", "io off stb", 32'(s_stb), 0);
    chk("R5", "io off err/data", {r_err, r_data[30:0]}, 0);
    access(1, 16'h01F6, 3'd1, 32'h10);
    chk("R5", "io off select kept", 32'(dev_sel), 0);
    access(0, 16'h01F2, 3'd3, 0);
    chk("R9", "bad size with io off", 32'(r_err), 1);
    io_en = 1'b1;
  endtask

  task automatic t_errors;
    access(0, 16'h01F2, 3'd3, 0);
    chk("R9", "size 3 err", 32'(r_err), 1);
    chk("R9", "size 3 stb", 32'(s_stb), 0);
    access(1, 16'h0800, 3'd1, 0);
    chk("R10", "miss err", 32'(r_err), 1);
    access(0, 16'h01F2, 3'd1, 0);
    chk("R10", "hit no err", 32'(r_err), 0);
  endtask

  task automatic t_priority;
    setbar(1, 16'h01F6);
    access(0, 16'h01F7, 3'd1, 0);
    chk("R2", "overlap goes to cmd", {s_stb, s_kind, s_off}, {2'd1, 2'd0, 4'd7});
    access(0, 16'h01F8, 3'd1, 0);
    chk("R2", "ctl past cmd", {s_stb, s_kind, s_off}, {2'd1, 2'd1, 4'd2});
  endtask

  task automatic t_base_zero;
    setbar(0, 16'h0000);
    access(0, 16'h01F3, 3'd1, 0);
    chk("R11", "zero base ignored", {s_stb, s_kind, s_off}, {2'd1, 2'd0, 4'd3});
    access(0, 16'h0003, 3'd1, 0);
    chk("R11", "no window at zero", 32'(r_err), 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    setbar(0, 16'h01F0);
    setbar(1, 16'h03F4);
    setbar(2, 16'h0170);
    setbar(3, 16'h0374);
    setbar(4, 16'hC000);
    io_en = 1'b1;
    bm_en = 1'b1;
    t_routes();
    t_select();
    t_bm();
    t_io_gate();
    t_errors();
    t_priority();
    t_base_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule